// File: doc/BRIEF.md
# One-Shot Cycle Countdown Timer

This block is a single-shot down-counter that measures a number of clock cycles and then signals an interrupt. Software, through decode logic that sits outside this block, presents a strobe with a count value. The counter takes that value at once, even if an earlier count is still running down. It then subtracts one on every clock edge until it reaches zero.

The edge on which the count steps from one to zero produces a request that lasts one cycle. That request drives interrupt line 0 of the interrupt controller, and the controller holds it as a pending bit. A count of zero means the timer is idle. The block never reloads on its own, so it stays idle until the next load. The current count is visible on an output, so software or a bench can follow it.

Top module: `cdt_timer`

## Requirements
- R1: While reset is asserted (rst_n low) and on the first sample after it, count_o reads 0 and irq_o reads 0.
- R2: When load_en is 1 at a rising clock edge, count_o equals load_val after that edge, whatever count was in progress.
- R3: When count_o is non-zero and load_en is 0 at a rising edge, count_o is one less after that edge.
- R4: When count_o is 0 and load_en is 0, count_o stays 0 and irq_o stays 0. There is no automatic reload.
- R5: irq_o is 1 for exactly one cycle: the cycle in which count_o first reads 0 after reading 1. With a load of N (N ≥ 1) and no further loads, this is N edges after the load edge.
- R6: If load_en is 1 on the edge where the count would step from 1 to 0, the load takes effect and irq_o stays 0.
- R7: Loading the value 0 during a countdown stops the timer, and no request is produced for that countdown.
- R8: The counter uses the full 32-bit range. A load of 32'hFFFF_FFFF steps to 32'hFFFF_FFFE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| load_en | input | 1 | Strobe that loads a new count this edge |
| load_val | input | 32 | Count to load; 0 disables the timer |
| count_o | output | 32 | Current count |
| irq_o | output | 1 | One-cycle request for interrupt line 0 |

## Verification
A load and the last decrement can fall on the same clock edge. The bench provokes this by running a countdown until count_o reads 1 and then asserting load_en for the very next edge. It does this once with a non-zero value and once with zero. The outcome is judged at the ports: count_o must hold the loaded value and irq_o must stay low, both on that cycle and on the cycles that follow.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  localparam int unsigned CDT_W = 32;

  // next count: a load has priority; otherwise step toward zero and stop there
  function automatic logic [CDT_W-1:0] cdt_next(
    input logic [CDT_W-1:0] cur,
    input logic             ld,
    input logic [CDT_W-1:0] ld_val
  );
    if (ld)              return ld_val;
    else if (cur != '0)  return cur - 1'b1;
    else                 return cur;
  endfunction

  // expiry event: last step from one to zero, not overridden by a load
  function automatic logic cdt_expires(
    input logic [CDT_W-1:0] cur,
    input logic             ld
  );
    return (cur == {{(CDT_W-1){1'b0}}, 1'b1}) && !ld;
  endfunction
endpackage

// File: rtl/cdt_step.sv
module cdt_step
  import cdt_pkg::*;
#(
  parameter int unsigned W = CDT_W
) (
  input  logic [W-1:0] cur_cnt,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] nxt_cnt,
  output logic         expire_ev
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  always_comb begin
    if (ld)                nxt_cnt = ld_val;
    else if (cur_cnt != '0) nxt_cnt = cur_cnt - ONE;
    else                   nxt_cnt = cur_cnt;
    expire_ev = (cur_cnt == ONE) && !ld;
  end
endmodule

// File: rtl/cdt_count_reg.sv
module cdt_count_reg #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end
endmodule

// File: rtl/cdt_irq_gen.sv
module cdt_irq_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic expire_ev,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= expire_ev;
  end

  // R5
  irq_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
endmodule

// File: rtl/cdt_timer.sv
module cdt_timer
  import cdt_pkg::*;
#(
  parameter int unsigned W = CDT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_en,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] count_o,
  output logic         irq_o
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         expire_ev;
  logic         irq_q;

  cdt_step #(.W(W)) u_step (
    .cur_cnt  (cnt_q),
    .ld       (load_en),
    .ld_val   (load_val),
    .nxt_cnt  (cnt_d),
    .expire_ev(expire_ev)
  );

  cdt_count_reg #(.W(W)) u_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (cnt_d),
    .q    (cnt_q)
  );

  cdt_irq_gen u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .expire_ev(expire_ev),
    .irq      (irq_q)
  );

  assign count_o = cnt_q;
  assign irq_o   = irq_q;

  // R2
  load_takes_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> count_o == $past(load_val));

  // R3
  decrement_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count_o != '0 && !load_en) |=> count_o == $past(count_o) - ONE);

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count_o == '0 && !load_en) |=> (count_o == '0 && !irq_o));

  // R5
  irq_at_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count_o == ONE && !load_en) |=> (irq_o && count_o == '0));

  // R6
  load_beats_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count_o == ONE && load_en) |=> !irq_o);
endmodule

// File: tb/cdt_timer_tb.sv
module cdt_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_en = 1'b0;
  logic [31:0] load_val = '0;
  logic [31:0] count_o;
  logic        irq_o;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  cdt_timer u_dut (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_val(load_val),
    .count_o(count_o), .irq_o(irq_o)
  );

  // vector: load value, negedges to wait after the load, expected count, expected irq
  typedef struct packed {
    logic [31:0] val;
    logic [7:0]  wait_n;
    logic [31:0] exp_cnt;
    logic        exp_irq;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{32'd5,        8'd0, 32'd5,        1'b0},
    '{32'd5,        8'd2, 32'd3,        1'b0},
    '{32'd5,        8'd4, 32'd1,        1'b0},
    '{32'd5,        8'd5, 32'd0,        1'b1},
    '{32'd5,        8'd6, 32'd0,        1'b0},
    '{32'd1,        8'd1, 32'd0,        1'b1},
    '{32'd3,        8'd2, 32'd1,        1'b0},
    '{32'hFFFFFFFF, 8'd1, 32'hFFFFFFFE, 1'b0},
    '{32'd0,        8'd3, 32'd0,        1'b0}
  };

  task automatic check(input string req, input logic [31:0] act_c, input logic [31:0] exp_c,
                       input logic act_i, input logic exp_i);
    checks++;
    if (act_c !== exp_c || act_i !== exp_i) begin
      failures++;
      $display("FAIL %s: count=%0h irq=%0b expected count=%0h irq=%0b",
               req, act_c, act_i, exp_c, exp_i);
    end
  endtask

  // drive the strobe for one edge; returns at the negedge after it
  task automatic do_load(input logic [31:0] v);
    @(negedge clk);
    load_en = 1'b1;
    load_val = v;
    @(negedge clk);
    load_en = 1'b0;
  endtask

  initial begin
    #200000;
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic saw_irq;
    repeat (3) @(negedge clk);
    check("R1 in reset", count_o, 32'd0, irq_o, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", count_o, 32'd0, irq_o, 1'b0);

    // table walk: R2 R3 R5 R8 R4
    for (int i = 0; i < NV; i++) begin
      do_load(VECS[i].val);
      for (int k = 0; k < int'(VECS[i].wait_n); k++) @(negedge clk);
      check($sformatf("R2/R3/R5/R8 vector %0d", i), count_o, VECS[i].exp_cnt,
            irq_o, VECS[i].exp_irq);
      // drain any running count
      do_load(32'd0);
    end

    // R4: idle stays idle, no reload after expiry
    do_load(32'd2);
    repeat (2) @(negedge clk);
    check("R5 expiry pulse", count_o, 32'd0, irq_o, 1'b1);
    saw_irq = 1'b0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (irq_o || count_o != 0) saw_irq = 1'b1;
    end
    check("R4 no reload after expiry", count_o, 32'd0, saw_irq, 1'b0);

    // R2: reload mid-count replaces value
    do_load(32'd10);
    repeat (3) @(negedge clk);
    check("R3 mid run", count_o, 32'd7, irq_o, 1'b0);
    do_load(32'd2);
    check("R2 replace in progress", count_o, 32'd2, irq_o, 1'b0);
    @(negedge clk);
    @(negedge clk);
    check("R5 after replaced count", count_o, 32'd0, irq_o, 1'b1);

    // R6: load on the 1->0 edge with a non-zero value
    do_load(32'd3);
    repeat (2) @(negedge clk);
    check("R6 setup count one", count_o, 32'd1, irq_o, 1'b0);
    load_en = 1'b1; load_val = 32'd7;
    @(negedge clk);
    load_en = 1'b0;
    check("R6 load wins", count_o, 32'd7, irq_o, 1'b0);
    @(negedge clk);
    check("R6 no late irq", count_o, 32'd6, irq_o, 1'b0);
    do_load(32'd0);

    // R6 and R7: load zero on the 1->0 edge
    do_load(32'd2);
    @(negedge clk);
    check("R7 setup count one", count_o, 32'd1, irq_o, 1'b0);
    load_en = 1'b1; load_val = 32'd0;
    @(negedge clk);
    load_en = 1'b0;
    check("R7 zero load at expiry", count_o, 32'd0, irq_o, 1'b0);
    saw_irq = 1'b0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      if (irq_o) saw_irq = 1'b1;
    end
    check("R7 no irq after cancel", count_o, 32'd0, saw_irq, 1'b0);

    // R7: cancel early in a long countdown
    do_load(32'd6);
    @(negedge clk);
    do_load(32'd0);
    saw_irq = 1'b0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (irq_o) saw_irq = 1'b1;
    end
    check("R7 early cancel", count_o, 32'd0, saw_irq, 1'b0);

    // R1: reset during a countdown
    do_load(32'd50);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset mid run", count_o, 32'd0, irq_o, 1'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 idle after reset", count_o, 32'd0, irq_o, 1'b0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule